// File: doc/BRIEF.md
# Host-to-Firmware Command Mailbox

The block is a memory-mapped mailbox between a host processor and a management microcontroller. The host writes a 16-byte outbound payload and then a command word, which starts a transaction. The command word carries an opcode, a sub-command id, a payload size and a flag that asks for a completion interrupt. Accepting a command sets busy and sends a one-cycle doorbell pulse to the firmware side.

The firmware side sees the latched command word and the outbound payload as flat vectors. It fills a 16-byte inbound buffer word by word and then gives a done strobe with an error bit and an 8-bit error code. The done strobe clears busy and stores the error result. If the command asked for it, the block also sets a sticky completion flag and sends a one-cycle interrupt pulse to the host. The host clears the flag by writing the status register.

Top module: `host_fw_mailbox`

## Requirements
- R1: After reset, busy, error, error code, the completion flag and both buffers are zero. Status then reads `INIT_ID << 8` and `fw_obuf_o` is zero.
- R2: A host write with any byte enable to offset 0x00 while idle is accepted. The word masked by the byte enables appears on `fw_cmd_o` and status bit 0 (busy) reads 1. `fw_doorbell_o` is high for exactly the one cycle after the accepting edge.
- R3: A command write while busy is ignored. It gives no doorbell and `fw_cmd_o` keeps the earlier command.
- R4: `fw_done_i` while busy clears busy in the same edge that latches `fw_err_i` into status bit 1 and `fw_err_code_i` into status bits [23:16].
- R5: Accepting a new command clears the error bit and the error code.
- R6: If command bit 8 was set, completion sets status bit 2 and pulses `h_irq_o` for one cycle after the done edge. If bit 8 was clear, neither happens.
- R7: A host write to offset 0x04 with byte enable 0 high and data bit 2 set clears status bit 2. The same write with data bit 2 clear leaves the flag unchanged.
- R8: Offsets 0x80–0x8F form the outbound buffer. Word index is addr[3:2] and byte b of word w is `fw_obuf_o[32*w+8*b +: 8]`. Byte-enabled host writes update only the enabled bytes. Host reads there return zero, and reads of offset 0x00 return zero too.
- R9: Offsets 0x90–0x9F return the inbound buffer word at index addr[3:2]. Each byte whose byte enable is low reads as zero, which makes single-byte reads possible. The firmware writes word `fw_ibuf_idx_i` when `fw_ibuf_we_i` is high.
- R10: Status bits [7:4] give the sub-command id (command bits [15:12]) of the last accepted command. Bits [15:8] give the parameter `INIT_ID`, and bits 3 and [31:24] read zero.
- R11: `fw_done_i` while idle has no effect on status and produces no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_addr_i | input | 8 | Host byte address |
| h_we_i | input | 1 | Host write enable |
| h_be_i | input | 4 | Host byte enables |
| h_wdata_i | input | 32 | Host write data |
| h_rdata_o | output | 32 | Host read data (combinational, byte-masked) |
| h_irq_o | output | 1 | Completion interrupt pulse to host |
| fw_doorbell_o | output | 1 | Doorbell pulse to firmware |
| fw_cmd_o | output | 32 | Latched command word |
| fw_obuf_o | output | 128 | Outbound buffer contents |
| fw_ibuf_we_i | input | 1 | Firmware inbound buffer write enable |
| fw_ibuf_idx_i | input | 2 | Inbound buffer word index |
| fw_ibuf_wdata_i | input | 32 | Inbound buffer write data |
| fw_done_i | input | 1 | Firmware completion strobe |
| fw_err_i | input | 1 | Firmware error bit |
| fw_err_code_i | input | 8 | Firmware error code |

## Verification
The hardest case to reach is a second command that lands while the first one is still open. Once the firmware answers, this is no longer possible. The bench therefore issues a command, holds back the done strobe, writes a different command word, and checks that no doorbell occurs and the latched command is unchanged. A second case is an error left over from a failed command. To show that the next acceptance clears it, a vector with an error is followed directly by a new command, and status is read before the firmware responds.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0] OFF_CMD  = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_OBUF = 8'h80;
  localparam logic [7:0] OFF_IBUF = 8'h90;

  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] size;
    logic [3:0] sub_id;
    logic [2:0] rsv_lo;
    logic       ioc;
    logic [7:0] opcode;
  } cmd_t;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    for (int b = 0; b < 4; b++) be_mask[8*b +: 8] = {8{be[b]}};
  endfunction
endpackage

// File: rtl/mbx_wordbuf.sv
module mbx_wordbuf #(
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [3:0]            be_i,
  input  logic [31:0]           wdata_i,
  output logic [WORDS*32-1:0]   data_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                     byte_q <= '0;
        else if (we_i && be_i[b] && idx_i == IDX_W'(w))  byte_q <= wdata_i[8*b +: 8];
      end
      assign data_o[32*w + 8*b +: 8] = byte_q;
    end
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  cmd_t       cmd_i,
  input  logic       ack_i,
  input  logic       done_i,
  input  logic       err_i,
  input  logic [7:0] err_code_i,
  output cmd_t       cmd_o,
  output logic       busy_o,
  output logic       err_o,
  output logic [7:0] err_code_o,
  output logic       irq_flag_o,
  output logic       doorbell_o,
  output logic       irq_o
);
  cmd_t       cmd_q;
  logic       busy_q, err_q, flag_q, db_q, irq_q;
  logic [7:0] code_q;
  logic       accept, finish;

  assign accept = cmd_we_i && !busy_q;
  assign finish = done_i && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      flag_q <= 1'b0;
      db_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      db_q  <= accept;
      irq_q <= finish && cmd_q.ioc;
      if (accept) begin
        cmd_q  <= cmd_i;
        busy_q <= 1'b1;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= err_i;
        code_q <= err_code_i;
      end
      // set wins over a same-cycle acknowledge
      if (finish && cmd_q.ioc) flag_q <= 1'b1;
      else if (ack_i)          flag_q <= 1'b0;
    end
  end

  assign cmd_o      = cmd_q;
  assign busy_o     = busy_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
  assign irq_flag_o = flag_q;
  assign doorbell_o = db_q;
  assign irq_o      = irq_q;

  // R2
  doorbell_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_q |=> !db_q);
  // R2
  doorbell_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_q |-> busy_q);
  // R3
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(cmd_q));
  // R6
  irq_needs_ioc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cmd_q.ioc && flag_q && !busy_q));
  // R4
  done_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_q) |=> !busy_q);
endmodule

// File: rtl/host_fw_mailbox.sv
module host_fw_mailbox
  import mbx_pkg::*;
#(
  parameter int         BUF_BYTES = 16,
  parameter logic [7:0] INIT_ID   = 8'h3C,
  localparam int        BUF_WORDS = BUF_BYTES / 4,
  localparam int        IDX_W     = $clog2(BUF_WORDS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             h_addr_i,
  input  logic                   h_we_i,
  input  logic [3:0]             h_be_i,
  input  logic [31:0]            h_wdata_i,
  output logic [31:0]            h_rdata_o,
  output logic                   h_irq_o,
  output logic                   fw_doorbell_o,
  output logic [31:0]            fw_cmd_o,
  output logic [BUF_BYTES*8-1:0] fw_obuf_o,
  input  logic                   fw_ibuf_we_i,
  input  logic [IDX_W-1:0]       fw_ibuf_idx_i,
  input  logic [31:0]            fw_ibuf_wdata_i,
  input  logic                   fw_done_i,
  input  logic                   fw_err_i,
  input  logic [7:0]             fw_err_code_i
);
  localparam int REG_LSB = IDX_W + 2;

  logic [31:0]            wmask;
  logic                   hit_cmd, hit_stat, hit_obuf, hit_ibuf;
  logic [IDX_W-1:0]       widx;
  cmd_t                   cmd_q;
  logic                   busy, err, flag;
  logic [7:0]             code;
  logic [BUF_BYTES*8-1:0] ibuf;
  logic [31:0]            stat_word, rd_raw;

  assign wmask    = be_mask(h_be_i);
  assign widx     = h_addr_i[REG_LSB-1:2];
  assign hit_cmd  = h_addr_i == OFF_CMD;
  assign hit_stat = h_addr_i == OFF_STAT;
  assign hit_obuf = h_addr_i[7:REG_LSB] == OFF_OBUF[7:REG_LSB];
  assign hit_ibuf = h_addr_i[7:REG_LSB] == OFF_IBUF[7:REG_LSB];

  mbx_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (h_we_i && hit_cmd && |h_be_i),
    .cmd_i      (cmd_t'(h_wdata_i & wmask)),
    .ack_i      (h_we_i && hit_stat && h_be_i[0] && h_wdata_i[2]),
    .done_i     (fw_done_i),
    .err_i      (fw_err_i),
    .err_code_i (fw_err_code_i),
    .cmd_o      (cmd_q),
    .busy_o     (busy),
    .err_o      (err),
    .err_code_o (code),
    .irq_flag_o (flag),
    .doorbell_o (fw_doorbell_o),
    .irq_o      (h_irq_o)
  );

  mbx_wordbuf #(.WORDS(BUF_WORDS)) i_obuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (h_we_i && hit_obuf),
    .idx_i   (widx),
    .be_i    (h_be_i),
    .wdata_i (h_wdata_i),
    .data_o  (fw_obuf_o)
  );

  mbx_wordbuf #(.WORDS(BUF_WORDS)) i_ibuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (fw_ibuf_we_i),
    .idx_i   (fw_ibuf_idx_i),
    .be_i    (4'hF),
    .wdata_i (fw_ibuf_wdata_i),
    .data_o  (ibuf)
  );

  assign fw_cmd_o  = cmd_q;
  assign stat_word = {8'h00, code, INIT_ID, cmd_q.sub_id, 1'b0, flag, err, busy};

  always_comb begin
    rd_raw = '0;
    if (hit_stat)      rd_raw = stat_word;
    else if (hit_ibuf) rd_raw = ibuf[32*widx +: 32];
  end
  assign h_rdata_o = rd_raw & wmask;

  // R6
  irq_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_irq_o |-> flag);
  // R8
  obuf_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_obuf || hit_cmd) |-> h_rdata_o == '0);
endmodule

// File: tb/test_host_fw_mailbox.sv
`timescale 1ns/1ps
module test_host_fw_mailbox;
  localparam logic [7:0] ID = 8'h3C;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic [7:0]   h_addr = '0;
  logic         h_we = 1'b0;
  logic [3:0]   h_be = '0;
  logic [31:0]  h_wdata = '0, h_rdata;
  logic         h_irq, fw_db;
  logic [31:0]  fw_cmd;
  logic [127:0] fw_obuf;
  logic         ib_we = 1'b0;
  logic [1:0]   ib_idx = '0;
  logic [31:0]  ib_wdata = '0;
  logic         done = 1'b0, ferr = 1'b0;
  logic [7:0]   fcode = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  host_fw_mailbox i_host_fw_mailbox (
    .clk_i(clk), .rst_ni(rst_ni), .h_addr_i(h_addr), .h_we_i(h_we), .h_be_i(h_be),
    .h_wdata_i(h_wdata), .h_rdata_o(h_rdata), .h_irq_o(h_irq), .fw_doorbell_o(fw_db),
    .fw_cmd_o(fw_cmd), .fw_obuf_o(fw_obuf), .fw_ibuf_we_i(ib_we), .fw_ibuf_idx_i(ib_idx),
    .fw_ibuf_wdata_i(ib_wdata), .fw_done_i(done), .fw_err_i(ferr), .fw_err_code_i(fcode));

  // {cmd, err, code, inbound word}
  localparam logic [72:0] VEC [4] = '{
    {32'h0003_11FF, 1'b0, 8'h00, 32'hA5A5_0001},
    {32'h0008_2042, 1'b1, 8'h5A, 32'h1234_5678},
    {32'h0004_F1C3, 1'b1, 8'hE7, 32'hDEAD_BEEF},
    {32'h0000_0010, 1'b0, 8'h00, 32'h0F0F_F0F0}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_be = be; h_wdata = d; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0; h_be = '0;
  endtask

  task automatic hread(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    h_addr = a; h_be = be;
    #0.5 d = h_rdata;
  endtask

  task automatic fw_finish(input logic e, input logic [7:0] c);
    @(negedge clk);
    done = 1'b1; ferr = e; fcode = c;
    @(negedge clk);
    done = 1'b0; ferr = 1'b0; fcode = '0;
  endtask

  task automatic fw_fill(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk);
    ib_we = 1'b1; ib_idx = i; ib_wdata = d;
    @(negedge clk);
    ib_we = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    hread(8'h04, 4'hF, rd); chk("R1 status", rd, {16'h0, ID, 8'h00});
    chk("R1 obuf", fw_obuf, '0);
    hread(8'h94, 4'hF, rd); chk("R1 ibuf", rd, 32'h0);
    chk("R1 irq/db", {h_irq, fw_db}, 2'b00);

    for (int v = 0; v < 4; v++) begin
      logic [31:0] c;
      logic        e, ioc;
      logic [7:0]  code;
      logic [31:0] w;
      {c, e, code, w} = VEC[v];
      ioc = c[8];
      hwrite(8'h00, 4'hF, c);
      chk("R2 doorbell", fw_db, 1'b1);
      chk("R2 cmd", fw_cmd, c);
      // R5 R10 busy set, error cleared, sub id echoed
      hread(8'h04, 4'hF, rd); chk("R5 status after accept", rd, {16'h0, ID, c[15:12], 4'b0001});
      @(negedge clk);
      chk("R2 doorbell one cycle", fw_db, 1'b0);
      fw_fill(v[1:0], w);
      fw_finish(e, code);
      chk("R6 irq pulse", h_irq, ioc);
      hread(8'h04, 4'hF, rd);
      chk("R4 status after done", rd, {8'h0, code, ID, c[15:12], 1'b0, ioc, e, 1'b0});
      @(negedge clk);
      chk("R6 irq single", h_irq, 1'b0);
      hread({6'b100100, v[1:0]} << 0, 4'hF, rd);
      hread(8'h90 + 8'(4*v), 4'hF, rd); chk("R9 ibuf word", rd, w);
      hwrite(8'h04, 4'h1, 32'h4);
      hread(8'h04, 4'hF, rd); chk("R7 ack clears", rd[2], 1'b0);
    end

    // R3 command while busy ignored
    hwrite(8'h00, 4'hF, 32'h0001_5101);
    @(negedge clk);
    hwrite(8'h00, 4'hF, 32'h0002_6077);
    chk("R3 no doorbell", fw_db, 1'b0);
    chk("R3 cmd kept", fw_cmd, 32'h0001_5101);
    fw_finish(1'b0, 8'h00);
    // R7 write without bit 2 keeps flag
    hwrite(8'h04, 4'hF, 32'h0000_0003);
    hread(8'h04, 4'hF, rd); chk("R7 flag kept", rd[2], 1'b1);
    hwrite(8'h04, 4'h1, 32'h0000_0004);
    hread(8'h04, 4'hF, rd); chk("R7 flag cleared", rd, {16'h0, ID, 8'h50});

    // R11 done while idle
    fw_finish(1'b1, 8'h99);
    chk("R11 no irq", h_irq, 1'b0);
    hread(8'h04, 4'hF, rd); chk("R11 status unchanged", rd, {16'h0, ID, 8'h50});

    // R8 outbound buffer byte write
    hwrite(8'h84, 4'b0010, 32'h0000_AB00);
    chk("R8 obuf byte", fw_obuf, 128'h0000_AB00 << 32);
    hwrite(8'h8C, 4'hF, 32'h7766_5544);
    chk("R8 obuf word", fw_obuf[127:96], 32'h7766_5544);
    hread(8'h84, 4'hF, rd); chk("R8 obuf reads zero", rd, 32'h0);
    hread(8'h00, 4'hF, rd); chk("R8 cmd reads zero", rd, 32'h0);

    // R9 byte read
    fw_fill(2'd2, 32'h1122_3344);
    hread(8'h98, 4'b0100, rd); chk("R9 byte read", rd, 32'h0022_0000);
    hread(8'h98, 4'hF, rd); chk("R9 word read", rd, 32'h1122_3344);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule